// File: doc/BRIEF.md
# Triggered ADC Conversion Sequencer

This block runs one analog-to-digital conversion each time a chosen hardware trigger fires. Up to four trigger sources come in as pulse lines, for example a compare-equal pulse from a PWM timer. A select input picks the one that is allowed to start a conversion. No conversion starts on its own: every result needs a fresh rising edge on the selected source while the sequencer is idle.

After an accepted trigger the sequencer closes the sample-and-hold switch for a programmable number of clocks, never fewer than six. It then performs a 12-step successive-approximation search. On each step it presents a trial code to an external comparator and keeps or drops that bit according to the comparator's answer. The finished 12-bit unsigned code (0 for 0 V, 4095 for full scale) is written to the result register. In the same edge the sequencer enters a one-cycle done state that drives the end-of-conversion pulse. When enabled, that pulse is also copied to the interrupt line. Triggers that arrive while a conversion is in progress are ignored and counted.

Top module: `adc_seq_top`

## Requirements
- R1: While reset is applied and after it is released, `busy`, `sh_hold`, `eoc`, `irq`, `sar_code`, `result` and `ovr_cnt` are all zero until a conversion is started.
- R2: A conversion starts only on a rising edge (low in one cycle, high in the next) of `trig_in[trig_sel]` seen while idle. Edges on the other trigger lines have no effect on `busy`, `sh_hold` or `ovr_cnt`.
- R3: `sh_hold` is high for exactly max(`win_cfg`, 6) cycles, starting in the cycle after the clock edge that accepts the trigger. A setting below 6 behaves as 6.
- R4: After the sample phase come 12 compare cycles. In compare step k (k = 0..11) the trial bit is bit 11−k. `sar_code` shows the bits already decided with the trial bit set, and the trial bit is kept when `cmp_ge` is high in that cycle.
- R5: `result` holds the final code, and `eoc` is high for exactly one cycle. That cycle is the (max(`win_cfg`,6)+13)-th cycle after the trigger was driven, and `result` is already valid in it.
- R6: `irq` repeats the `eoc` pulse when `irq_en` is 1 and stays low when `irq_en` is 0.
- R7: After the `eoc` cycle the sequencer is idle (`busy` low) and stays idle until the next accepted trigger.
- R8: Each rising edge of the selected trigger seen while `busy` is high increments `ovr_cnt`, which saturates at 255. Such an edge neither restarts nor lengthens the running conversion.
- R9: `result` changes only in an `eoc` cycle and otherwise holds its value, whatever the comparator input does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trig_in | input | 4 | Trigger source pulse lines |
| trig_sel | input | 2 | Index of the trigger line that may start a conversion |
| win_cfg | input | 8 | Sample window length in clocks (minimum 6 applied) |
| irq_en | input | 1 | Lets the end-of-conversion pulse drive `irq` |
| cmp_ge | input | 1 | Comparator answer: held input is at or above `sar_code` |
| sh_hold | output | 1 | Sample switch closed (sample phase) |
| sar_code | output | 12 | Trial code for the comparator DAC, zero outside compare |
| busy | output | 1 | A conversion is in progress (sample, compare or done) |
| result | output | 12 | Last converted code, unsigned |
| eoc | output | 1 | One-cycle end-of-conversion pulse |
| irq | output | 1 | Interrupt pulse |
| ovr_cnt | output | 8 | Saturating count of triggers ignored while busy |

## Verification
A wrong phase counter shows as a `sh_hold` run of the wrong length, or an `eoc` that arrives early or late. Either is seen within one conversion, at most about 270 cycles after the trigger. A broken bit index or accumulator shows as a wrong trial code on `sar_code` in the very compare step where it goes wrong, and then as a wrong `result` at the following `eoc`. A sequencer that fails to return to idle, or that restarts on a mistimed trigger, shows as `busy` staying high, an extra or missing `eoc`, or an `ovr_cnt` that differs from the number of pulses sent.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int RES_W   = 12;
  localparam int MIN_WIN = 6;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SAMPLE  = 2'd1,
    ST_CONVERT = 2'd2,
    ST_DONE    = 2'd3
  } seq_state_t;

endpackage

// File: rtl/adc_rst_sync.sv
module adc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel #(
  parameter int NUM_SRC = 4,
  parameter int SEL_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] trig_in,
  input  logic [SEL_W-1:0]   trig_sel,
  output logic               trig_evt
);

  logic [NUM_SRC-1:0] prev_q;
  logic [NUM_SRC-1:0] rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= trig_in;
    end
  end

  assign rise = trig_in & ~prev_q;

  always_comb begin
    trig_evt = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (trig_sel == SEL_W'(i)) begin
        trig_evt = rise[i];
      end
    end
  end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int WIN_W = 8,
  parameter int BIT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_evt,
  input  logic [WIN_W-1:0] win_cfg,
  output seq_state_t       state,
  output logic [BIT_W-1:0] bit_idx
);

  localparam logic [WIN_W-1:0] WIN_FLOOR = WIN_W'(MIN_WIN);
  localparam logic [BIT_W-1:0] TOP_BIT   = BIT_W'(RES_W - 1);

  seq_state_t       state_q, state_d;
  logic [WIN_W-1:0] cnt_q, cnt_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [WIN_W-1:0] eff_win;
  logic             cnt_en, bit_en;

  assign eff_win = (win_cfg < WIN_FLOOR) ? WIN_FLOOR : win_cfg;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    cnt_en  = 1'b0;
    bit_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (trig_evt) begin
          state_d = ST_SAMPLE;
          cnt_d   = eff_win - WIN_W'(1);
          cnt_en  = 1'b1;
        end
      end
      ST_SAMPLE: begin
        if (cnt_q == '0) begin
          state_d = ST_CONVERT;
          bit_d   = TOP_BIT;
          bit_en  = 1'b1;
        end else begin
          cnt_d  = cnt_q - WIN_W'(1);
          cnt_en = 1'b1;
        end
      end
      ST_CONVERT: begin
        if (bit_q == '0) begin
          state_d = ST_DONE;
        end else begin
          bit_d  = bit_q - BIT_W'(1);
          bit_en = 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= '0;
    end else if (bit_en) begin
      bit_q <= bit_d;
    end
  end

  assign state   = state_q;
  assign bit_idx = bit_q;

endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
  parameter int RES_W = 12,
  parameter int BIT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [BIT_W-1:0] bit_idx,
  input  logic             cmp_ge,
  output logic [RES_W-1:0] sar_code,
  output logic [RES_W-1:0] result
);

  logic [RES_W-1:0] acc_q, acc_d;
  logic [RES_W-1:0] trial;
  logic             acc_en, res_en, last;

  assign trial = acc_q | (RES_W'(1) << bit_idx);
  assign last  = (bit_idx == '0);

  always_comb begin
    acc_en = clr | step;
    acc_d  = acc_q;
    if (clr) begin
      acc_d = '0;
    end else if (step && cmp_ge) begin
      acc_d = trial;
    end
  end

  assign res_en = step & last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
    end else if (res_en) begin
      result <= acc_d;
    end
  end

  assign sar_code = step ? trial : '0;

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int SEL_W   = $clog2(NUM_SRC),
  parameter int WIN_W   = 8,
  parameter int OVR_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] trig_in,
  input  logic [SEL_W-1:0]   trig_sel,
  input  logic [WIN_W-1:0]   win_cfg,
  input  logic               irq_en,
  input  logic               cmp_ge,
  output logic               sh_hold,
  output logic [RES_W-1:0]   sar_code,
  output logic               busy,
  output logic [RES_W-1:0]   result,
  output logic               eoc,
  output logic               irq,
  output logic [OVR_W-1:0]   ovr_cnt
);

  localparam int BIT_W = $clog2(RES_W);
  localparam logic [OVR_W-1:0] OVR_MAX = '1;

  logic             rst_sync_n;
  logic             trig_evt;
  seq_state_t       state;
  logic [BIT_W-1:0] bit_idx;
  logic [OVR_W-1:0] ovr_q;
  logic             ovr_en;

  adc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  adc_trig_sel #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_trig (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .trig_in  (trig_in),
    .trig_sel (trig_sel),
    .trig_evt (trig_evt)
  );

  adc_seq_fsm #(.WIN_W(WIN_W), .BIT_W(BIT_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .trig_evt (trig_evt),
    .win_cfg  (win_cfg),
    .state    (state),
    .bit_idx  (bit_idx)
  );

  adc_sar_core #(.RES_W(RES_W), .BIT_W(BIT_W)) u_sar (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr      (state == ST_SAMPLE),
    .step     (state == ST_CONVERT),
    .bit_idx  (bit_idx),
    .cmp_ge   (cmp_ge),
    .sar_code (sar_code),
    .result   (result)
  );

  assign ovr_en = trig_evt && (state != ST_IDLE) && (ovr_q != OVR_MAX);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ovr_q <= '0;
    end else if (ovr_en) begin
      ovr_q <= ovr_q + OVR_W'(1);
    end
  end

  assign ovr_cnt = ovr_q;
  assign sh_hold = (state == ST_SAMPLE);
  assign busy    = (state != ST_IDLE);
  assign eoc     = (state == ST_DONE);
  assign irq     = eoc & irq_en;

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int RES_W = 12,
  parameter int OVR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sh_hold,
  input logic             busy,
  input logic             eoc,
  input logic             irq,
  input logic             irq_en,
  input logic [RES_W-1:0] result,
  input logic [OVR_W-1:0] ovr_cnt
);

  // R5
  eoc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |=> !eoc);

  // R3
  sample_to_compare_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sh_hold) |-> (busy && !eoc));

  // R7
  idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |=> !busy);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc |-> $stable(result));

  // R8
  overrun_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ovr_cnt) |-> $past(busy));

  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

endmodule

bind adc_seq_top adc_seq_chk #(.RES_W(12), .OVR_W(OVR_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .sh_hold (sh_hold),
  .busy    (busy),
  .eoc     (eoc),
  .irq     (irq),
  .irq_en  (irq_en),
  .result  (result),
  .ovr_cnt (ovr_cnt)
);

// File: tb/adc_seq_top_tb_top.sv
module adc_seq_top_tb_top;

  logic        clk;
  logic        rst_n;
  logic [3:0]  trig_in;
  logic [1:0]  trig_sel;
  logic [7:0]  win_cfg;
  logic        irq_en;
  logic        cmp_ge;
  logic        sh_hold;
  logic [11:0] sar_code;
  logic        busy;
  logic [11:0] result;
  logic        eoc;
  logic        irq;
  logic [7:0]  ovr_cnt;
  logic [11:0] ana;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  adc_seq_top dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_in  (trig_in),
    .trig_sel (trig_sel),
    .win_cfg  (win_cfg),
    .irq_en   (irq_en),
    .cmp_ge   (cmp_ge),
    .sh_hold  (sh_hold),
    .sar_code (sar_code),
    .busy     (busy),
    .result   (result),
    .eoc      (eoc),
    .irq      (irq),
    .ovr_cnt  (ovr_cnt)
  );

  // behavioural comparator stub of the converter
  assign cmp_ge = (ana >= sar_code);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int eff_win(input int w);
    return (w < 6) ? 6 : w;
  endfunction

  function automatic int sat_ovr(input int v);
    return (v > 255) ? 255 : v;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      check(1'b0, "watchdog", cycles, 150000);
      report();
    end
  end

  task automatic run_conv(input int src, input int win, input int val,
                          input int ien, input int n_ovr);
    int n, sh, ew, acc_e, code_e, b, ovr0;
    bit code_bad, irq_seen;
    @(negedge clk);
    trig_sel = 2'(src);
    win_cfg  = 8'(win);
    ana      = 12'(val);
    irq_en   = ien[0];
    ovr0     = int'(ovr_cnt);
    trig_in  = '0;
    trig_in[src] = 1'b1;
    ew = eff_win(win);
    n = 0; sh = 0; acc_e = 0; code_bad = 0; irq_seen = 0;
    while (n < 400) begin
      @(posedge clk);
      @(negedge clk);
      n++;
      trig_in[src] = (n >= 2) && (((n - 2) / 2) < n_ovr) && (((n - 2) % 2) == 0);
      if (sh_hold) sh++;
      if (n > ew && n <= ew + 12) begin
        b = 11 - (n - ew - 1);
        code_e = acc_e | (1 << b);
        if (int'(sar_code) != code_e) code_bad = 1;
        if (val >= code_e) acc_e = code_e;
      end
      if (irq) irq_seen = 1;
      if (eoc) break;
    end
    trig_in = '0;
    check(n == ew + 13, "R5 eoc latency", n, ew + 13);
    check(sh == ew, "R3 sample window length", sh, ew);
    check(!code_bad, "R4 trial code sequence", int'(code_bad), 0);
    check(int'(result) == val, "R5 result at eoc", int'(result), val);
    check(int'(irq_seen) == ien, "R6 irq follows irq_en", int'(irq_seen), ien);
    check(int'(ovr_cnt) == sat_ovr(ovr0 + n_ovr), "R8 overrun count",
          int'(ovr_cnt), sat_ovr(ovr0 + n_ovr));
    @(negedge clk);
    check(!eoc, "R5 eoc one cycle", int'(eoc), 0);
    check(!busy, "R7 idle after eoc", int'(busy), 0);
  endtask

  initial begin
    int r_before, o_before;
    bit seen;
    void'($urandom(32'd20251));
    rst_n = 1'b0; trig_in = '0; trig_sel = '0; win_cfg = '0; irq_en = 1'b0; ana = '0;
    repeat (3) @(negedge clk);
    check(!busy && !sh_hold && !eoc && !irq, "R1 reset controls", int'(busy), 0);
    check(result == 0 && sar_code == 0 && ovr_cnt == 0, "R1 reset data",
          int'(result), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && result == 0 && ovr_cnt == 0, "R1 after release", int'(busy), 0);

    // directed corners
    run_conv(0, 6, 0, 1, 0);
    run_conv(1, 0, 4095, 0, 0);
    run_conv(2, 5, 12'h800, 1, 1);
    run_conv(3, 7, 12'h7FF, 1, 2);
    run_conv(0, 255, 1234, 1, 0);

    // R2: unselected source pulse
    @(negedge clk);
    trig_sel = 2'd0; o_before = int'(ovr_cnt);
    trig_in[2] = 1'b1;
    @(negedge clk);
    trig_in[2] = 1'b0;
    seen = 0;
    repeat (20) begin
      @(negedge clk);
      if (busy || sh_hold) seen = 1;
    end
    check(!seen, "R2 unselected trigger ignored", int'(seen), 0);
    check(int'(ovr_cnt) == o_before, "R2 no overrun from other line",
          int'(ovr_cnt), o_before);

    // R7 and R9: no self restart, result holds while comparator input moves
    r_before = int'(result);
    seen = 0;
    repeat (40) begin
      @(negedge clk);
      ana = 12'($urandom % 4096);
      if (busy || eoc) seen = 1;
    end
    check(!seen, "R7 no conversion without trigger", int'(seen), 0);
    check(int'(result) == r_before, "R9 result holds", int'(result), r_before);

    // random conversions
    for (int i = 0; i < 16; i++) begin
      run_conv(int'($urandom % 4), int'($urandom % 40), int'($urandom % 4096),
               int'($urandom % 2), int'($urandom % 4));
    end

    // R8 saturation
    run_conv(1, 255, 100, 1, 130);
    run_conv(2, 255, 3000, 0, 130);
    check(ovr_cnt == 8'd255, "R8 saturated", int'(ovr_cnt), 255);

    done = 1;
    report();
  end

endmodule